// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Per-Line Ownership

This block is a general-purpose I/O peripheral for up to 32 pad lines, reached over a simple single-cycle 32-bit register bus. It holds two complete register banks: an *open* bank that any bus master may use at any time, and a *guarded* bank that answers only while an external `permit` input is high. Each bank has its own drive, output-enable, interrupt polarity, interrupt enable and pending-flag registers, plus read-only views of the pad inputs.

A per-line ownership register picks, for each line, which bank drives the pad and which bank detects interrupts on it. A set ownership bit gives the line to the open bank, and a clear bit gives it to the guarded bank. The ownership register is itself guarded. Pad inputs are resynchronised by a two-flop chain before any register or interrupt logic sees them. Each bank raises its own level interrupt output while any enabled pending flag is set.

Bus words are byte-swapped against the register bit numbering, which gives big-endian byte order on the bus. Bus addresses are word indices. Word index N is byte offset 4·N.

Top module: `dualbank_gpio`

## Requirements
- R1: After reset, all registers in both banks and the ownership register are zero. Every line belongs to the guarded bank, `pad_out` and `pad_oe` are zero, and both interrupt outputs are low.
- R2: Ownership bit i = 1 makes `pad_out[i]` and `pad_oe[i]` follow the open bank's DRIVE and OE bit i. Ownership bit i = 0 makes them follow the guarded bank's bits. An OE bit of 1 enables the driver.
- R3: The guarded bank (word indices 8–14) and the ownership register (word 7) ignore writes while `permit` is low, and reads of them return zero. The open bank (words 0–6) can be read and written whatever the value of `permit`.
- R4: Register bits [8k+7:8k] travel on bus data bits [31−8k:24−8k] for k = 0..3, in both directions.
- R5: `bus_rdata` holds the addressed register in the cycle after a read request and is zero in every other cycle. Word 15 reads as zero.
- R6: Word layout inside each bank (guarded = open + 8): 0 PIN, 1 DRIVE, 2 OE, 3 MIRROR, 4 POL, 5 EN, 6 PEND. PIN returns the synchronised inputs of all lines. MIRROR returns them only for lines the bank owns and zero for the other lines. A pad change reaches the synchronised input after two clock edges.
- R7: A PEND bit is set in every cycle in which the bank owns the line and the line's synchronised input equals its POL bit (1 = active high, 0 = active low). The bit stays set after the condition ends.
- R8: Writing a one to a PEND bit clears it, and writing a zero leaves it unchanged. If a clear and a set fall in the same cycle, the set wins.
- R9: Each interrupt output (`irq_open`, `irq_guard`) is high exactly when its bank has a bit set in both PEND and EN.
- R10: DRIVE and OE bits written for lines a bank does not own have no effect on the pads. The values are kept and take effect when ownership moves to that bank. The pads change only after a bus write.
- R11: PIN and MIRROR are read-only, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| permit | input | 1 | Grants access to the guarded bank and the ownership register |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 4 | Word index of the register |
| bus_wdata | input | 32 | Write data, big-endian byte order |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| pad_in | input | LINES | Asynchronous pad inputs |
| pad_out | output | LINES | Pad output values |
| pad_oe | output | LINES | Pad output enables |
| irq_open | output | 1 | Open bank interrupt |
| irq_guard | output | 1 | Guarded bank interrupt |

## Verification
The bench starts with the ownership split across banks, so that a design muxing the pads by the wrong polarity of the ownership bit, or detecting interrupts in both banks, puts the wrong bits on `pad_out` or raises the wrong interrupt. It writes the guarded bank and the ownership register with `permit` low and then reads them back after raising `permit`. A design that lets a blocked write through, or returns data while blocked, reports a nonzero word. It clears a pending flag while the line still matches its polarity. If the clear wins, the flag reads back as zero. It uses an asymmetric bus word to catch a missing or wrong byte swap, and it writes the read-only views to show they keep their values.

// File: rtl/dgpio_pkg.sv
package dgpio_pkg;

  localparam int BUS_W  = 32;
  localparam int WADR_W = 4;

  // Register slot inside a bank; word index = {bank, slot}
  typedef enum logic [2:0] {
    SLOT_PIN    = 3'd0,
    SLOT_DRIVE  = 3'd1,
    SLOT_OE     = 3'd2,
    SLOT_MIRROR = 3'd3,
    SLOT_POL    = 3'd4,
    SLOT_EN     = 3'd5,
    SLOT_PEND   = 3'd6,
    SLOT_EXTRA  = 3'd7
  } slot_e;

  localparam int NBANK      = 2;
  localparam int BANK_OPEN  = 0;
  localparam int BANK_GUARD = 1;

endpackage

// File: rtl/dgpio_lanes.sv
module dgpio_lanes #(
  parameter int WIDTH      = 32,
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic [WIDTH-1:0] lanes_in,
  output logic [WIDTH-1:0] lanes_out
);
  localparam int NBYTES = WIDTH / 8;

  generate
    if (BIG_ENDIAN) begin : g_swap
      for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        assign lanes_out[8*k +: 8] = lanes_in[8*(NBYTES-1-k) +: 8];
      end
    end else begin : g_pass
      assign lanes_out = lanes_in;
    end
  endgenerate

endmodule

// File: rtl/dgpio_sync.sv
module dgpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign chain_d[s] = async_in;
      end else begin : g_rest
        assign chain_d[s] = chain_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/dgpio_bank.sv
module dgpio_bank
  import dgpio_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  slot_e            wr_slot,
  input  logic [LINES-1:0] wr_bits,
  input  logic [LINES-1:0] own,
  input  logic [LINES-1:0] pin,
  output logic [LINES-1:0] drive_q,
  output logic [LINES-1:0] oe_q,
  output logic [LINES-1:0] pol_q,
  output logic [LINES-1:0] en_q,
  output logic [LINES-1:0] pend_q,
  output logic             irq
);
  logic             drive_ce, oe_ce, pol_ce, en_ce;
  logic [LINES-1:0] clr_mask, hit, pend_d;

  // Next-state
  always_comb begin
    drive_ce = wr_stb && (wr_slot == SLOT_DRIVE);
    oe_ce    = wr_stb && (wr_slot == SLOT_OE);
    pol_ce   = wr_stb && (wr_slot == SLOT_POL);
    en_ce    = wr_stb && (wr_slot == SLOT_EN);
    clr_mask = (wr_stb && (wr_slot == SLOT_PEND)) ? wr_bits : '0;
    hit      = own & ~(pin ^ pol_q);
    pend_d   = (pend_q & ~clr_mask) | hit;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= '0;
      oe_q    <= '0;
      pol_q   <= '0;
      en_q    <= '0;
      pend_q  <= '0;
    end else begin
      if (drive_ce) drive_q <= wr_bits;
      if (oe_ce)    oe_q    <= wr_bits;
      if (pol_ce)   pol_q   <= wr_bits;
      if (en_ce)    en_q    <= wr_bits;
      pend_q <= pend_d;
    end
  end

  assign irq = |(pend_q & en_q);

endmodule

// File: rtl/dualbank_gpio.sv
module dualbank_gpio
  import dgpio_pkg::*;
#(
  parameter int LINES       = 32,
  parameter int SYNC_STAGES = 2,
  parameter bit BIG_ENDIAN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              permit,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [WADR_W-1:0] bus_waddr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [LINES-1:0]  pad_in,
  output logic [LINES-1:0]  pad_out,
  output logic [LINES-1:0]  pad_oe,
  output logic              irq_open,
  output logic              irq_guard
);
  // Bus decode
  logic [BUS_W-1:0] wr_word;
  logic [LINES-1:0] wr_bits;
  slot_e            acc_slot;
  logic             acc_guard, wr_req, rd_req, blocked;
  logic [NBANK-1:0] bank_wr;
  logic             owner_ce;

  dgpio_lanes #(.WIDTH(BUS_W), .BIG_ENDIAN(BIG_ENDIAN)) u_win (
    .lanes_in (bus_wdata),
    .lanes_out(wr_word)
  );

  always_comb begin
    wr_bits   = wr_word[LINES-1:0];
    acc_slot  = slot_e'(bus_waddr[2:0]);
    acc_guard = bus_waddr[3];
    wr_req    = bus_sel && bus_wr;
    rd_req    = bus_sel && !bus_wr;
    blocked   = (acc_guard || (acc_slot == SLOT_EXTRA)) && !permit;
    bank_wr[BANK_OPEN]  = wr_req && !acc_guard;
    bank_wr[BANK_GUARD] = wr_req && acc_guard && permit;
    owner_ce  = wr_req && !acc_guard && (acc_slot == SLOT_EXTRA) && permit;
  end

  // Ownership register
  logic [LINES-1:0] owner_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        owner_q <= '0;
    else if (owner_ce) owner_q <= wr_bits;
  end

  // Input synchroniser
  logic [LINES-1:0] pin_sync;
  dgpio_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(pad_in),
    .sync_out(pin_sync)
  );

  // Banks
  logic [NBANK-1:0][LINES-1:0] own_v, drv_v, oe_v, pol_v, en_v, pend_v;
  logic [NBANK-1:0]            irq_v;

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      if (b == BANK_OPEN) begin : g_own_open
        assign own_v[b] = owner_q;
      end else begin : g_own_guard
        assign own_v[b] = ~owner_q;
      end
      dgpio_bank #(.LINES(LINES)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (bank_wr[b]),
        .wr_slot(acc_slot),
        .wr_bits(wr_bits),
        .own    (own_v[b]),
        .pin    (pin_sync),
        .drive_q(drv_v[b]),
        .oe_q   (oe_v[b]),
        .pol_q  (pol_v[b]),
        .en_q   (en_v[b]),
        .pend_q (pend_v[b]),
        .irq    (irq_v[b])
      );
    end
  endgenerate

  assign irq_open  = irq_v[BANK_OPEN];
  assign irq_guard = irq_v[BANK_GUARD];

  // Pad steering
  generate
    for (genvar i = 0; i < LINES; i++) begin : g_pad
      assign pad_out[i] = owner_q[i] ? drv_v[BANK_OPEN][i] : drv_v[BANK_GUARD][i];
      assign pad_oe[i]  = owner_q[i] ? oe_v[BANK_OPEN][i]  : oe_v[BANK_GUARD][i];
    end
  endgenerate

  // Read path
  logic [LINES-1:0] view;
  logic [BUS_W-1:0] rd_word, rd_lanes, rdata_d;
  logic             bsel;

  always_comb begin
    bsel = acc_guard;
    view = '0;
    case (acc_slot)
      SLOT_PIN:    view = pin_sync;
      SLOT_DRIVE:  view = drv_v[bsel];
      SLOT_OE:     view = oe_v[bsel];
      SLOT_MIRROR: view = pin_sync & own_v[bsel];
      SLOT_POL:    view = pol_v[bsel];
      SLOT_EN:     view = en_v[bsel];
      SLOT_PEND:   view = pend_v[bsel];
      SLOT_EXTRA:  view = acc_guard ? '0 : owner_q;
      default:     view = '0;
    endcase
    if (blocked) view = '0;
    rd_word = '0;
    rd_word[LINES-1:0] = view;
  end

  dgpio_lanes #(.WIDTH(BUS_W), .BIG_ENDIAN(BIG_ENDIAN)) u_rout (
    .lanes_in (rd_word),
    .lanes_out(rd_lanes)
  );

  assign rdata_d = rd_req ? rd_lanes : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rdata_d;
  end

endmodule

// File: rtl/dualbank_gpio_chk.sv
module dualbank_gpio_chk #(
  parameter int LINES = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             permit,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [3:0]       bus_waddr,
  input logic [31:0]      bus_rdata,
  input logic [LINES-1:0] pad_out,
  input logic [LINES-1:0] pad_oe,
  input logic             irq_open,
  input logic             irq_guard
);

  // R10
  pads_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> ($stable(pad_out) && $stable(pad_oe)));

  // R3
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && (bus_waddr[3] || bus_waddr == 4'd7) && !permit)
      |=> ($stable(pad_out) && $stable(pad_oe)));

  // R3
  locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (bus_waddr[3] || bus_waddr == 4'd7) && !permit)
      |=> (bus_rdata == 32'd0));

  // R5
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> (bus_rdata == 32'd0));

  // R8
  open_irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_open) |-> $past(bus_sel && bus_wr && !bus_waddr[3]));

  // R8
  guard_irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_guard) |-> $past(bus_sel && bus_wr && bus_waddr[3] && permit));

endmodule

bind dualbank_gpio dualbank_gpio_chk #(.LINES(LINES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .permit   (permit),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_waddr(bus_waddr),
  .bus_rdata(bus_rdata),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .irq_open (irq_open),
  .irq_guard(irq_guard)
);

// File: tb/dualbank_gpio_bench.sv
`timescale 1ns/1ps
module dualbank_gpio_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        permit, bus_sel, bus_wr;
  logic [3:0]  bus_waddr;
  logic [31:0] bus_wdata, bus_rdata, pad_in, pad_out, pad_oe;
  logic        irq_open, irq_guard;

  always #2 clk = ~clk;

  dualbank_gpio u_dualbank_gpio (
    .clk(clk), .rst_n(rst_n), .permit(permit), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_open(irq_open), .irq_guard(irq_guard)
  );

  int checks = 0;
  int fails  = 0;
  bit started = 0;
  int cycles = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_own, m_s1, m_s2, m_rd;
  logic [31:0] m_drv [2];
  logic [31:0] m_oe  [2];
  logic [31:0] m_pol [2];
  logic [31:0] m_en  [2];
  logic [31:0] m_pend[2];

  function automatic logic [31:0] swap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [31:0] owned(input int b);
    return (b == 0) ? m_own : ~m_own;
  endfunction

  function automatic logic [31:0] model_read(input logic [3:0] a, input logic p);
    int b;
    logic [31:0] v;
    b = a[3] ? 1 : 0;
    if ((b == 1 || a == 4'd7) && !p) return 32'd0;
    case (a[2:0])
      3'd0: v = m_s2;
      3'd1: v = m_drv[b];
      3'd2: v = m_oe[b];
      3'd3: v = m_s2 & owned(b);
      3'd4: v = m_pol[b];
      3'd5: v = m_en[b];
      3'd6: v = m_pend[b];
      default: v = (b == 0) ? m_own : 32'd0;
    endcase
    return swap(v);
  endfunction

  logic [31:0] nw, npend0, npend1, clr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_own = 0; m_s1 = 0; m_s2 = 0; m_rd = 0;
      for (int b = 0; b < 2; b++) begin
        m_drv[b] = 0; m_oe[b] = 0; m_pol[b] = 0; m_en[b] = 0; m_pend[b] = 0;
      end
    end else begin
      nw = swap(bus_wdata);
      m_rd = (bus_sel && !bus_wr) ? model_read(bus_waddr, permit) : 32'd0;
      clr = (bus_sel && bus_wr && bus_waddr == 4'd6) ? nw : 32'd0;
      npend0 = (m_pend[0] & ~clr) | (owned(0) & ~(m_s2 ^ m_pol[0]));
      clr = (bus_sel && bus_wr && bus_waddr == 4'd14 && permit) ? nw : 32'd0;
      npend1 = (m_pend[1] & ~clr) | (owned(1) & ~(m_s2 ^ m_pol[1]));
      if (bus_sel && bus_wr) begin
        if (bus_waddr == 4'd7) begin
          if (permit) m_own = nw;
        end else if (!bus_waddr[3] || permit) begin
          case (bus_waddr[2:0])
            3'd1: m_drv[bus_waddr[3]] = nw;
            3'd2: m_oe[bus_waddr[3]]  = nw;
            3'd4: m_pol[bus_waddr[3]] = nw;
            3'd5: m_en[bus_waddr[3]]  = nw;
            default: ;
          endcase
        end
      end
      m_pend[0] = npend0;
      m_pend[1] = npend1;
      m_s2 = m_s1;
      m_s1 = pad_in;
    end
  end

  // Every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started && rst_n) begin
      chk("R2 pad_out", pad_out, (m_own & m_drv[0]) | (~m_own & m_drv[1]));
      chk("R2 pad_oe",  pad_oe,  (m_own & m_oe[0])  | (~m_own & m_oe[1]));
      chk("R9 irq_open",  {31'd0, irq_open},  {31'd0, |(m_pend[0] & m_en[0])});
      chk("R9 irq_guard", {31'd0, irq_guard}, {31'd0, |(m_pend[1] & m_en[1])});
      chk("R5 rdata", bus_rdata, m_rd);
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_waddr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 0; bus_waddr = a;
    @(posedge clk); #1;
    bus_sel = 0;
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    rst_n = 0; permit = 1; bus_sel = 0; bus_wr = 0; bus_waddr = 0;
    bus_wdata = 0; pad_in = 0;
    idle(3);
    @(negedge clk); rst_n = 1; started = 1;
    idle(2);

    // R1 reset state
    chk("R1 pad_out reset", pad_out, 32'd0);
    chk("R1 pad_oe reset",  pad_oe,  32'd0);
    chk("R1 irqs reset", {30'd0, irq_open, irq_guard}, 32'd0);
    rd(4'd7, 32'd0, "R1 owner reset");
    rd(4'd6, 32'd0, "R1 open pend reset");

    // R4 byte order, R2 open ownership
    wr(4'd7, 32'hFFFF_FFFF);
    wr(4'd1, 32'h1122_3344);
    wr(4'd2, 32'hFFFF_FFFF);
    idle(1);
    chk("R4 pad_out lanes", pad_out, 32'h4433_2211);
    chk("R2 pad_oe open", pad_oe, 32'hFFFF_FFFF);
    rd(4'd1, 32'h1122_3344, "R4 readback lanes");

    // R10 writes to a non-owning bank
    wr(4'd9, 32'hFFFF_FFFF);
    idle(1);
    chk("R10 guarded drive no effect", pad_out, 32'h4433_2211);
    wr(4'd7, 32'h0000_00FF);
    idle(1);
    chk("R2 split pad_out", pad_out, 32'h44FF_FFFF);
    chk("R2 split pad_oe",  pad_oe,  32'hFF00_0000);

    // R3 permit gating
    permit = 0;
    wr(4'd10, 32'hFFFF_FFFF);
    wr(4'd7, 32'h0000_0000);
    idle(1);
    chk("R3 blocked writes", pad_oe, 32'hFF00_0000);
    rd(4'd9, 32'd0, "R3 blocked guarded read");
    rd(4'd7, 32'd0, "R3 blocked owner read");
    rd(4'd1, 32'h1122_3344, "R3 open bank always");
    permit = 1;
    rd(4'd9, 32'hFFFF_FFFF, "R3 guarded data kept");
    rd(4'd10, 32'd0, "R3 blocked OE write ignored");
    rd(4'd7, 32'h0000_00FF, "R3 blocked owner write ignored");

    // R6 input views, R11 read-only
    pad_in = 32'h0000_00A5;
    idle(4);
    rd(4'd0,  32'hA500_0000, "R6 open PIN");
    rd(4'd8,  32'hA500_0000, "R6 guarded PIN");
    rd(4'd3,  32'h0000_0000, "R6 open MIRROR");
    rd(4'd11, 32'hA500_0000, "R6 guarded MIRROR");
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd11, 32'h0000_0000);
    rd(4'd0,  32'hA500_0000, "R11 PIN read-only");
    rd(4'd11, 32'hA500_0000, "R11 MIRROR read-only");
    rd(4'd15, 32'd0, "R5 unmapped word");

    // R7 / R8 / R9 open bank, active high
    wr(4'd4, 32'hFFFF_FFFF);
    wr(4'd6, 32'hFFFF_FFFF);
    wr(4'd5, 32'hFFFF_FFFF);
    idle(1);
    chk("R9 no pend no irq", {31'd0, irq_open}, 32'd0);
    pad_in = 32'h0100_00A5;
    idle(4);
    chk("R7 active-high sets irq", {31'd0, irq_open}, 32'd1);
    rd(4'd6, 32'h0000_0001, "R7 pend bit 24");
    wr(4'd6, 32'h0000_0001);
    rd(4'd6, 32'h0000_0001, "R8 set wins over clear");
    pad_in = 32'h0000_00A5;
    idle(4);
    wr(4'd6, 32'h0000_0000);
    idle(1);
    chk("R8 zero write keeps flag", {31'd0, irq_open}, 32'd1);
    wr(4'd6, 32'h0000_0001);
    idle(1);
    chk("R8 w1c clears", {31'd0, irq_open}, 32'd0);

    // R7 / R9 guarded bank, active low then active high
    wr(4'd13, 32'h0200_0000);
    idle(1);
    chk("R7 active-low guarded irq", {31'd0, irq_guard}, 32'd1);
    wr(4'd12, 32'h0200_0000);
    wr(4'd14, 32'h0200_0000);
    idle(1);
    chk("R9 guarded irq cleared", {31'd0, irq_guard}, 32'd0);
    idle(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule